// File: doc/BRIEF.md
# String Comparator Mode Controller with Character Entry

This block is the control layer of a two-string comparator. An operator sets a character code on an 8-bit switch bank and presses an entry button. Each clean press stores that code in the next character slot. The first `STR_LEN` presses fill the reference string and the next `STR_LEN` presses fill the comparison string. After that, entry wraps back to the first reference slot. Both strings are presented in parallel to the compute engines, which sit outside this block.

A separate 8-bit mode code chooses what two seven-segment digits show: nothing, a lamp test, the edit distance, or the substring search result. Two events cause a one-cycle start pulse to the matching engine: the mode code changes, or the last comparison character is entered. Engine results are captured when their done strobes arrive. They are decoded into active-high segment patterns and driven from registers. The button input is synchronised and debounced, and each accepted press turns into exactly one single-cycle pulse.

Top module: `strcmp_mode_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, both digits, both start outputs and every character slot read zero, and the next press stores into reference slot 0.
- R2: The button counts as pressed or released only after its synchronised level has differed from the accepted level for `DEB_CYCLES` consecutive cycles. Each accepted press stores exactly one character, and shorter bounces store nothing.
- R3: Presses number 0 to `STR_LEN-1` fill reference slots 0 upward. Slot k occupies bits `[8k+7:8k]` of `ref_str`. The next `STR_LEN` presses fill comparison slots the same way. The press after that overwrites reference slot 0.
- R4: Mode code 0x00 drives both digits to 0x00 (all segments off).
- R5: Mode code 0x01 drives both digits to 0x7F (every segment lit).
- R6: Mode code 0x02 shows the captured edit distance on `seg_lo`, and `seg_hi` is blank.
- R7: Mode code 0x04 shows the captured position on `seg_lo` and the digit 1 on `seg_hi` when the captured found flag is set. When the flag is clear, both digits show 0.
- R8: Any mode code other than 0x00, 0x01, 0x02 and 0x04 blanks both digits.
- R9: Segment bit 0 is segment a and bit 6 is segment g, and both are active high. Digits 0 to 9 encode as 3F 06 5B 4F 66 6D 7D 07 7F 6F (hex). Values 10 to 15 show only segment g (0x40).
- R10: When the sampled mode code differs from the held one, the next cycle carries a one-cycle pulse. The pulse goes on `dist_start` for 0x02, on `srch_start` for 0x04, and on neither output for any other code.
- R11: Storing the last comparison character causes a one-cycle pulse on the start output of the currently held mode in the next cycle.
- R12: `dist_val` is captured when `dist_done` is high, and `srch_found`/`srch_pos` are captured when `srch_done` is high. Each captured value is held until the next strobe.
- R13: The digits follow the mode code and the captured results with two register stages. The code is held at one edge, and the digit registers load at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| char_sw | input | CHAR_W | Character code from the switch bank |
| enter_btn | input | 1 | Raw, asynchronous entry push button |
| mode_sw | input | MODE_W | Mode code |
| dist_done | input | 1 | Edit distance engine result strobe |
| dist_val | input | VAL_W | Edit distance result |
| srch_done | input | 1 | Search engine result strobe |
| srch_found | input | 1 | Search hit flag |
| srch_pos | input | VAL_W | Search hit position, counted from 1 |
| dist_start | output | 1 | One-cycle start to the edit distance engine |
| srch_start | output | 1 | One-cycle start to the search engine |
| ref_str | output | STR_LEN*CHAR_W | Reference string, slot 0 in the low byte |
| cmp_str | output | STR_LEN*CHAR_W | Comparison string, slot 0 in the low byte |
| seg_lo | output | 7 | Digit 1 segments, active high |
| seg_hi | output | 7 | Digit 2 segments, active high |

## Verification
The hardest situation to reach from the ports is a press that ends entry in the same cycle as a mode change, together with presses whose bounce lands just under the debounce window. The stimulus drives the button with short glitches of one and two cycles before and after each real hold. It completes a full two-string entry under several modes and flips the mode code on the cycle the tenth press is accepted. A behavioural model in the bench tracks every clock, so a single missed or doubled pulse anywhere shows up on the next comparison.

// File: rtl/scm_pkg.sv
package scm_pkg;

  localparam int SEG_W = 7;

  localparam logic [SEG_W-1:0] SEG_OFF  = 7'h00;
  localparam logic [SEG_W-1:0] SEG_ALL  = 7'h7F;
  localparam logic [SEG_W-1:0] SEG_DASH = 7'h40;

  typedef enum logic [1:0] {
    VIEW_BLANK,
    VIEW_TEST,
    VIEW_EDIT,
    VIEW_SRCH
  } view_e;

endpackage

// File: rtl/scm_one_pulse.sv
module scm_one_pulse #(
  parameter int DEB_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic btn_raw,
  output logic pulse
);
  localparam int CNT_W = (DEB_CYCLES > 1) ? $clog2(DEB_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEB_CYCLES - 1);

  logic             sync_a, sync_b;
  logic             held, held_prev;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_a    <= 1'b0;
      sync_b    <= 1'b0;
      held      <= 1'b0;
      held_prev <= 1'b0;
      cnt       <= '0;
    end else begin
      sync_a    <= btn_raw;
      sync_b    <= sync_a;
      held_prev <= held;
      if (sync_b == held) begin
        cnt <= '0;
      end else if (cnt == CNT_LAST) begin
        held <= sync_b;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign pulse = held & ~held_prev;

endmodule

// File: rtl/scm_entry_buf.sv
module scm_entry_buf #(
  parameter int CHAR_W  = 8,
  parameter int STR_LEN = 5
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [CHAR_W-1:0]         wr_data,
  output logic                      entry_done,
  output logic [STR_LEN*CHAR_W-1:0] ref_flat,
  output logic [STR_LEN*CHAR_W-1:0] cmp_flat
);
  localparam int SLOTS = 2 * STR_LEN;
  localparam int IDX_W = $clog2(SLOTS);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(SLOTS - 1);

  logic [IDX_W-1:0]  idx;
  logic [CHAR_W-1:0] ref_q [STR_LEN];
  logic [CHAR_W-1:0] cmp_q [STR_LEN];

  assign entry_done = wr_en && (idx == IDX_LAST);

  always_ff @(posedge clk) begin
    if (rst)             idx <= '0;
    else if (entry_done) idx <= '0;
    else if (wr_en)      idx <= idx + 1'b1;
  end

  for (genvar g = 0; g < STR_LEN; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)                                ref_q[g] <= '0;
      else if (wr_en && idx == IDX_W'(g))     ref_q[g] <= wr_data;
    end
    always_ff @(posedge clk) begin
      if (rst)                                       cmp_q[g] <= '0;
      else if (wr_en && idx == IDX_W'(g + STR_LEN))  cmp_q[g] <= wr_data;
    end
    assign ref_flat[g*CHAR_W +: CHAR_W] = ref_q[g];
    assign cmp_flat[g*CHAR_W +: CHAR_W] = cmp_q[g];
  end

endmodule

// File: rtl/scm_digit_enc.sv
module scm_digit_enc
  import scm_pkg::*;
#(
  parameter int VAL_W = 4
) (
  input  logic [VAL_W-1:0] value,
  output logic [SEG_W-1:0] seg
);
  always_comb begin
    if (value > VAL_W'(9)) begin
      seg = SEG_DASH;
    end else begin
      case (value[3:0])
        4'd0:    seg = 7'h3F;
        4'd1:    seg = 7'h06;
        4'd2:    seg = 7'h5B;
        4'd3:    seg = 7'h4F;
        4'd4:    seg = 7'h66;
        4'd5:    seg = 7'h6D;
        4'd6:    seg = 7'h7D;
        4'd7:    seg = 7'h07;
        4'd8:    seg = 7'h7F;
        default: seg = 7'h6F;
      endcase
    end
  end

endmodule

// File: rtl/strcmp_mode_ctrl.sv
module strcmp_mode_ctrl
  import scm_pkg::*;
#(
  parameter int CHAR_W     = 8,
  parameter int STR_LEN    = 5,
  parameter int MODE_W     = 8,
  parameter int VAL_W      = 4,
  parameter int DEB_CYCLES = 1000
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [CHAR_W-1:0]         char_sw,
  input  logic                      enter_btn,
  input  logic [MODE_W-1:0]         mode_sw,
  input  logic                      dist_done,
  input  logic [VAL_W-1:0]          dist_val,
  input  logic                      srch_done,
  input  logic                      srch_found,
  input  logic [VAL_W-1:0]          srch_pos,
  output logic                      dist_start,
  output logic                      srch_start,
  output logic [STR_LEN*CHAR_W-1:0] ref_str,
  output logic [STR_LEN*CHAR_W-1:0] cmp_str,
  output logic [SEG_W-1:0]          seg_lo,
  output logic [SEG_W-1:0]          seg_hi
);
  localparam logic [MODE_W-1:0] CODE_BLANK = MODE_W'(0);
  localparam logic [MODE_W-1:0] CODE_TEST  = MODE_W'(1);
  localparam logic [MODE_W-1:0] CODE_EDIT  = MODE_W'(2);
  localparam logic [MODE_W-1:0] CODE_SRCH  = MODE_W'(4);

  logic              btn_press;
  logic              entry_done;
  logic [MODE_W-1:0] mode_q;
  logic              mode_chg;
  view_e             view;
  logic [VAL_W-1:0]  dist_q, pos_q;
  logic              found_q;
  logic [VAL_W-1:0]  lo_val, hi_val;
  logic [SEG_W-1:0]  lo_enc, hi_enc;

  scm_one_pulse #(.DEB_CYCLES(DEB_CYCLES)) u_pulse (
    .clk     (clk),
    .rst     (rst),
    .btn_raw (enter_btn),
    .pulse   (btn_press)
  );

  scm_entry_buf #(.CHAR_W(CHAR_W), .STR_LEN(STR_LEN)) u_buf (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (btn_press),
    .wr_data    (char_sw),
    .entry_done (entry_done),
    .ref_flat   (ref_str),
    .cmp_flat   (cmp_str)
  );

  // Mode register and start pulse generation
  assign mode_chg = (mode_sw != mode_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q     <= CODE_BLANK;
      dist_start <= 1'b0;
      srch_start <= 1'b0;
    end else begin
      mode_q <= mode_sw;
      if (mode_chg) begin
        dist_start <= (mode_sw == CODE_EDIT);
        srch_start <= (mode_sw == CODE_SRCH);
      end else if (entry_done) begin
        dist_start <= (mode_q == CODE_EDIT);
        srch_start <= (mode_q == CODE_SRCH);
      end else begin
        dist_start <= 1'b0;
        srch_start <= 1'b0;
      end
    end
  end

  // Result capture from the engines
  always_ff @(posedge clk) begin
    if (rst) begin
      dist_q  <= '0;
      pos_q   <= '0;
      found_q <= 1'b0;
    end else begin
      if (dist_done) dist_q <= dist_val;
      if (srch_done) begin
        found_q <= srch_found;
        pos_q   <= srch_pos;
      end
    end
  end

  // Display selection
  always_comb begin
    unique case (mode_q)
      CODE_TEST: view = VIEW_TEST;
      CODE_EDIT: view = VIEW_EDIT;
      CODE_SRCH: view = VIEW_SRCH;
      default:   view = VIEW_BLANK;
    endcase
  end

  always_comb begin
    if (view == VIEW_EDIT) lo_val = dist_q;
    else if (found_q)      lo_val = pos_q;
    else                   lo_val = '0;
    hi_val = VAL_W'(found_q);
  end

  scm_digit_enc #(.VAL_W(VAL_W)) u_enc_lo (.value(lo_val), .seg(lo_enc));
  scm_digit_enc #(.VAL_W(VAL_W)) u_enc_hi (.value(hi_val), .seg(hi_enc));

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_lo <= SEG_OFF;
      seg_hi <= SEG_OFF;
    end else begin
      case (view)
        VIEW_TEST: begin seg_lo <= SEG_ALL; seg_hi <= SEG_ALL; end
        VIEW_EDIT: begin seg_lo <= lo_enc;  seg_hi <= SEG_OFF; end
        VIEW_SRCH: begin seg_lo <= lo_enc;  seg_hi <= hi_enc;  end
        default:   begin seg_lo <= SEG_OFF; seg_hi <= SEG_OFF; end
      endcase
    end
  end

endmodule

// File: rtl/scm_ctrl_chk.sv
module scm_ctrl_chk #(
  parameter int MODE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [MODE_W-1:0] mode_sw,
  input logic              press,
  input logic              dist_start,
  input logic              srch_start,
  input logic [6:0]        seg_lo,
  input logic [6:0]        seg_hi
);
  a_r2_press_single: assert property (@(posedge clk) disable iff (rst)
    press |=> !press);

  a_r10_start_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({dist_start, srch_start}));

  a_r10_edit_start: assert property (@(posedge clk) disable iff (rst)
    (mode_sw == MODE_W'(2) && $past(mode_sw) != MODE_W'(2) && !$past(rst)) |=> dist_start);

  a_r10_srch_start: assert property (@(posedge clk) disable iff (rst)
    (mode_sw == MODE_W'(4) && $past(mode_sw) != MODE_W'(4) && !$past(rst)) |=> srch_start);

  a_r5_lamp_test: assert property (@(posedge clk) disable iff (rst)
    (mode_sw == MODE_W'(1) && $past(mode_sw) == MODE_W'(1) && !$past(rst))
      |=> (seg_lo == 7'h7F && seg_hi == 7'h7F));

  a_r4_blank: assert property (@(posedge clk) disable iff (rst)
    (mode_sw == MODE_W'(0) && $past(mode_sw) == MODE_W'(0) && !$past(rst))
      |=> (seg_lo == 7'h00 && seg_hi == 7'h00));

endmodule

bind strcmp_mode_ctrl scm_ctrl_chk #(.MODE_W(MODE_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .mode_sw    (mode_sw),
  .press      (btn_press),
  .dist_start (dist_start),
  .srch_start (srch_start),
  .seg_lo     (seg_lo),
  .seg_hi     (seg_hi)
);

// File: tb/strcmp_mode_ctrl_bench.sv
module strcmp_mode_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int L   = 5;
  localparam int CW  = 8;
  localparam int DEB = 8;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [CW-1:0]  char_sw = '0;
  logic           enter_btn = 1'b0;
  logic [7:0]     mode_sw = '0;
  logic           dist_done = 1'b0;
  logic [3:0]     dist_val = '0;
  logic           srch_done = 1'b0;
  logic           srch_found = 1'b0;
  logic [3:0]     srch_pos = '0;
  logic           dist_start, srch_start;
  logic [L*CW-1:0] ref_str, cmp_str;
  logic [6:0]     seg_lo, seg_hi;

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  strcmp_mode_ctrl #(.CHAR_W(CW), .STR_LEN(L), .MODE_W(8), .VAL_W(4), .DEB_CYCLES(DEB))
    u_strcmp_mode_ctrl (
    .clk(clk), .rst(rst), .char_sw(char_sw), .enter_btn(enter_btn), .mode_sw(mode_sw),
    .dist_done(dist_done), .dist_val(dist_val), .srch_done(srch_done),
    .srch_found(srch_found), .srch_pos(srch_pos), .dist_start(dist_start),
    .srch_start(srch_start), .ref_str(ref_str), .cmp_str(cmp_str),
    .seg_lo(seg_lo), .seg_hi(seg_hi));

  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- reference model ----------------
  bit        m_s1, m_s2, m_db, m_dbp, m_press, m_fin, m_db_new;
  int        m_cnt, m_idx;
  logic [7:0] m_mode;
  bit        m_ds, m_ss, m_found;
  int        m_dist, m_pos;
  logic [6:0] m_lo, m_hi, t_lo, t_hi;
  logic [CW-1:0] m_ref [L];
  logic [CW-1:0] m_cmp [L];

  function automatic logic [6:0] enc(int v);
    case (v)
      0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
      4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
      8: return 7'h7F; 9: return 7'h6F;
      default: return 7'h40;
    endcase
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_s1 = 0; m_s2 = 0; m_db = 0; m_dbp = 0; m_cnt = 0; m_idx = 0;
      m_mode = 0; m_ds = 0; m_ss = 0; m_found = 0; m_dist = 0; m_pos = 0;
      m_lo = 0; m_hi = 0;
      for (int i = 0; i < L; i++) begin m_ref[i] = 0; m_cmp[i] = 0; end
    end else begin
      case (m_mode)
        8'h01:   begin t_lo = 7'h7F; t_hi = 7'h7F; end
        8'h02:   begin t_lo = enc(m_dist); t_hi = 7'h00; end
        8'h04:   begin t_lo = enc(m_found ? m_pos : 0); t_hi = enc(m_found ? 1 : 0); end
        default: begin t_lo = 7'h00; t_hi = 7'h00; end
      endcase
      m_press = m_db && !m_dbp;
      m_fin = 0;
      if (m_press) begin
        if (m_idx < L) m_ref[m_idx] = char_sw;
        else           m_cmp[m_idx-L] = char_sw;
        m_fin = (m_idx == 2*L-1);
        m_idx = m_fin ? 0 : m_idx + 1;
      end
      if (mode_sw != m_mode) begin
        m_ds = (mode_sw == 8'h02); m_ss = (mode_sw == 8'h04);
      end else if (m_fin) begin
        m_ds = (m_mode == 8'h02); m_ss = (m_mode == 8'h04);
      end else begin
        m_ds = 0; m_ss = 0;
      end
      m_mode = mode_sw;
      m_db_new = m_db;
      if (m_s2 == m_db) m_cnt = 0;
      else if (m_cnt == DEB-1) begin m_db_new = m_s2; m_cnt = 0; end
      else m_cnt++;
      m_dbp = m_db; m_db = m_db_new; m_s2 = m_s1; m_s1 = enter_btn;
      if (dist_done) m_dist = dist_val;
      if (srch_done) begin m_found = srch_found; m_pos = srch_pos; end
      m_lo = t_lo; m_hi = t_hi;
    end
  end

  function automatic string seg_tag(logic [7:0] md);
    case (md)
      8'h00: return "R4 R13";
      8'h01: return "R5 R13";
      8'h02: return "R6 R9 R12 R13";
      8'h04: return "R7 R9 R12 R13";
      default: return "R8 R13";
    endcase
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  logic [L*CW-1:0] e_ref, e_cmp;
  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      for (int i = 0; i < L; i++) begin
        e_ref[i*CW +: CW] = m_ref[i];
        e_cmp[i*CW +: CW] = m_cmp[i];
      end
      check(seg_lo == m_lo, {seg_tag(m_mode), " seg_lo"}, 64'(seg_lo), 64'(m_lo));
      check(seg_hi == m_hi, {seg_tag(m_mode), " seg_hi"}, 64'(seg_hi), 64'(m_hi));
      check(dist_start == m_ds, "R10 R11 dist_start", 64'(dist_start), 64'(m_ds));
      check(srch_start == m_ss, "R10 R11 srch_start", 64'(srch_start), 64'(m_ss));
      check(ref_str == e_ref, "R2 R3 ref_str", 64'(ref_str), 64'(e_ref));
      check(cmp_str == e_cmp, "R2 R3 cmp_str", 64'(cmp_str), 64'(e_cmp));
    end
  end

  // ---------------- stimulus ----------------
  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic btn_level(bit v, int n);
    @(negedge clk); enter_btn = v;
    wait_cyc(n - 1);
  endtask

  task automatic enter_char(logic [7:0] c);
    @(negedge clk); char_sw = c;
    btn_level(1, 2); btn_level(0, 1); btn_level(1, 1); btn_level(0, 2);
    btn_level(1, DEB + 6);
    btn_level(0, 1); btn_level(1, 2);
    btn_level(0, DEB + 6);
  endtask

  task automatic dist_result(logic [3:0] v);
    @(negedge clk); dist_val = v; dist_done = 1;
    @(negedge clk); dist_done = 0;
    wait_cyc(4);
  endtask

  task automatic srch_result(bit f, logic [3:0] p);
    @(negedge clk); srch_found = f; srch_pos = p; srch_done = 1;
    @(negedge clk); srch_done = 0;
    wait_cyc(4);
  endtask

  task automatic set_mode(logic [7:0] m, int hold);
    @(negedge clk); mode_sw = m;
    wait_cyc(hold);
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    wait_cyc(4);
    rst = 0;
    // R1: reset state visible on the first cycle after reset
    check(seg_lo == 0 && seg_hi == 0, "R1 digits", 64'({seg_hi, seg_lo}), 0);
    check(!dist_start && !srch_start, "R1 starts", 64'({dist_start, srch_start}), 0);
    check(ref_str == 0 && cmp_str == 0, "R1 strings", 64'(ref_str), 0);

    set_mode(8'h01, 6);
    set_mode(8'h00, 6);
    set_mode(8'h80, 6);
    set_mode(8'h03, 6);
    set_mode(8'h02, 6);
    dist_result(4'd3);
    dist_result(4'd12);
    for (int k = 0; k < 2*L; k++) enter_char(8'h41 + 8'(k));
    dist_result(4'd0);
    set_mode(8'h04, 6);
    srch_result(1, 4'd2);
    srch_result(0, 4'd3);
    srch_result(1, 4'd9);
    // wrap to reference slot 0 under search mode
    for (int k = 0; k < 2*L; k++) enter_char(8'h61 + 8'(k));
    // mode change on the cycle that completes entry
    for (int k = 0; k < 2*L - 1; k++) enter_char(8'h30 + 8'(k));
    @(negedge clk); char_sw = 8'h7A; enter_btn = 1;
    wait_cyc(DEB + 2);
    while (!(m_db && !m_dbp)) @(negedge clk);
    mode_sw = 8'h02;
    wait_cyc(4);
    enter_btn = 0;
    wait_cyc(DEB + 8);
    for (int v = 0; v < 16; v++) dist_result(4'(v));
    set_mode(8'h01, 5);
    set_mode(8'h04, 5);
    set_mode(8'h02, 5);
    set_mode(8'h00, 5);
    summary();
  end

  initial begin
    wait (cyc >= 100000);
    tests++; fails++;
    $display("FAIL watchdog actual=%0d expected<100000", cyc);
    summary();
  end

endmodule